// File: doc/BRIEF.md
# Vector Floating-Point Exception Trap Encoder

This block sits behind the lanes of a vector floating-point unit and turns the IEEE exception flags that each lane raises into one decision per vector operation. Lanes are presented one per cycle in ascending index order after a start strobe. For every lane, the flags are compared against the trap-enable field of a 32-bit floating-point control register. The first lane whose enabled flags call for a trap ends the operation. That lane produces a one-cycle trap pulse carrying an 8-bit code, built from the lane index and a prioritised cause number.

When the operation ends without a trap, the OR of the flags from every evaluated lane is merged into the flag field of the control register. A commit pulse then tells the surrounding datapath that the destination may be written. On a trap, the flag field is left alone and no commit is given. An operation ends early after lane 0 in single-element mode, and a per-operation bit can keep an enabled inexact condition, on its own, from trapping.

Top module: `vfx_trap_encoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `trap_valid`, `trap_code`, `op_done`, `commit`, `sum_flags` and `ctrl_q` are all zero.
- R2: A `ctrl_wr` cycle loads `ctrl_wdata` into `ctrl_q`, visible the next cycle. It takes precedence over a flag merge in the same cycle. Bits 31:24 of `ctrl_q` change only through `ctrl_wr`.
- R3: Lane flag bits are [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact. The enable bits are `ctrl_q[31:27]`, in the same order. A lane is a trap candidate only when its flags ANDed with the enables are nonzero, so a lane with no flags never traps.
- R4: The trap cause is the highest-priority enabled flag: invalid = 1, divide-by-zero = 2, overflow = 3, underflow = 4, inexact = 5.
- R5: The cycle after the trapping lane is accepted, `trap_valid` is high for one cycle. In that cycle `trap_code[7:4]` holds the lane index and `trap_code[3:0]` holds the cause. `trap_code` is zero in every other cycle.
- R6: `inexact_suppress`, captured at `op_start`, stops an enabled inexact condition from trapping when it is the only enabled flag of the lane.
- R7: A trapping lane ends the operation: `op_done` pulses together with `trap_valid`. Lanes presented after that, until the next `op_start`, are ignored, and `sum_flags` stays unchanged.
- R8: When `single_elem` is captured high at `op_start`, the operation ends after lane 0 and later lanes are ignored.
- R9: `sum_flags` is the OR of the flags of all accepted lanes of the current operation, including a trapping lane. It is zero the cycle after `op_start`. A lane presented in the `op_start` cycle is ignored.
- R10: An operation that ends without a trap ORs the final summary into `ctrl_q[23:19]` (same bit order as R3) and pulses `commit`. An operation that ends in a trap leaves `ctrl_q` unchanged and gives no `commit`.
- R11: Without a trap or single-element mode, the operation ends when lane `NUM_LANES-1` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Load strobe for the control register |
| ctrl_wdata | input | 32 | Value to load into the control register |
| op_start | input | 1 | Begins a vector operation, clears the summary |
| single_elem | input | 1 | Single-element mode, captured at start |
| inexact_suppress | input | 1 | Inexact-only suppression, captured at start |
| lane_valid | input | 1 | A lane's flags are presented this cycle |
| lane_idx | input | LANE_W | Index of the presented lane |
| lane_flags | input | 5 | Exception flags of the presented lane |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_code | output | 8 | Lane index and cause of the trap |
| op_done | output | 1 | One-cycle pulse after the last evaluated lane |
| commit | output | 1 | Operation ended without trap; destination may be written |
| sum_flags | output | 5 | OR of flags of the accepted lanes |
| ctrl_q | output | 32 | Floating-point control register |

## Verification
The bench builds the block with its default parameters: four lanes, the enable field at bit 24 and the flag field at bit 16. With four lanes, a trap at the top lane index, with code 0x3n, is reachable, and so is a completion on lane 3. The lane index field also stays narrower than its nibble, which exercises the zero extension. A behavioural model runs alongside the design and is compared on every clock. It is driven through every trap cause and the inexact suppression. It also covers single-element ends, lanes ignored after a stop, and a register write colliding with a flag merge.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

  localparam int FLAG_W = 5;

  // Flag bit positions inside a lane's flag vector (and in the enable/flag fields)
  localparam int FB_INV  = 4;
  localparam int FB_DIVZ = 3;
  localparam int FB_OVF  = 2;
  localparam int FB_UNF  = 1;
  localparam int FB_INX  = 0;

  typedef enum logic [3:0] {
    CAUSE_NONE = 4'd0,
    CAUSE_INV  = 4'd1,
    CAUSE_DIVZ = 4'd2,
    CAUSE_OVF  = 4'd3,
    CAUSE_UNF  = 4'd4,
    CAUSE_INX  = 4'd5
  } cause_e;

endpackage

// File: rtl/vfx_lane_eval.sv
module vfx_lane_eval
  import vfx_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] enables,
  input  logic              suppress_inx,
  output cause_e            cause,
  output logic              hit
);

  logic [FLAG_W-1:0] cand;

  assign cand = flags & enables;

  always_comb begin
    cause = CAUSE_NONE;
    if (cand[FB_INV])                       cause = CAUSE_INV;
    else if (cand[FB_DIVZ])                 cause = CAUSE_DIVZ;
    else if (cand[FB_OVF])                  cause = CAUSE_OVF;
    else if (cand[FB_UNF])                  cause = CAUSE_UNF;
    else if (cand[FB_INX] && !suppress_inx) cause = CAUSE_INX;
  end

  assign hit = (cause != CAUSE_NONE);

endmodule

// File: rtl/vfx_op_seq.sv
module vfx_op_seq
  import vfx_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int LANE_W   = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic              single_in,
  input  logic              supp_in,
  input  logic              lane_valid,
  input  logic [LANE_W-1:0] lane_idx,
  input  logic [FLAG_W-1:0] lane_flags,
  input  cause_e            cause,
  input  logic              hit,
  output logic              supp_q,
  output logic              merge_en,
  output logic [FLAG_W-1:0] merge_flags,
  output logic              trap_valid,
  output logic [7:0]        trap_code,
  output logic              op_done,
  output logic              commit,
  output logic [FLAG_W-1:0] sum_flags
);

  localparam logic [LANE_W-1:0] LAST_IDX = LANE_W'(NUM_LANES - 1);

  logic              active_q;
  logic              single_q;
  logic              take;
  logic              last;
  logic [FLAG_W-1:0] sum_next;
  logic [3:0]        idx_nib;

  assign take     = active_q && lane_valid && !op_start;
  assign last     = hit || single_q || (lane_idx == LAST_IDX);
  assign sum_next = sum_flags | lane_flags;
  assign idx_nib  = 4'(lane_idx);

  assign merge_en    = take && last && !hit;
  assign merge_flags = sum_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      single_q   <= 1'b0;
      supp_q     <= 1'b0;
      sum_flags  <= '0;
      trap_valid <= 1'b0;
      trap_code  <= '0;
      op_done    <= 1'b0;
      commit     <= 1'b0;
    end else begin
      trap_valid <= 1'b0;
      trap_code  <= '0;
      op_done    <= 1'b0;
      commit     <= 1'b0;
      if (op_start) begin
        active_q  <= 1'b1;
        single_q  <= single_in;
        supp_q    <= supp_in;
        sum_flags <= '0;
      end else if (take) begin
        sum_flags  <= sum_next;
        trap_valid <= hit;
        trap_code  <= hit ? {idx_nib, 4'(cause)} : 8'h00;
        op_done    <= last;
        commit     <= last && !hit;
        if (last) active_q <= 1'b0;
      end
    end
  end

  // R7: a trap always closes the operation
  p_trap_ends_op_r7: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> op_done);

  // R10: commit and trap are mutually exclusive
  p_commit_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(trap_valid && commit));

  // R4: a reported cause is always one of the five codes
  p_cause_range_r4: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (trap_code[3:0] >= 4'd1 && trap_code[3:0] <= 4'd5));

  // R9: the summary is empty right after a start
  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    op_start |=> (sum_flags == '0));

  // R9: the summary only grows within an operation
  p_sum_grows_r9: assert property (@(posedge clk) disable iff (rst)
    !op_start |=> ((sum_flags & $past(sum_flags)) == $past(sum_flags)));

endmodule

// File: rtl/vfx_ctrl_reg.sv
module vfx_ctrl_reg
  import vfx_pkg::*;
#(
  parameter int CTRL_W  = 32,
  parameter int SUM_POS = 16,
  localparam int SUM_LO = SUM_POS + 8 - FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              merge_en,
  input  logic [FLAG_W-1:0] merge_flags,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [FLAG_W-1:0] flag_nxt;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_merge
    assign flag_nxt[b] = ctrl_q[SUM_LO + b] | merge_flags[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr) begin
      ctrl_q <= wdata;
    end else if (merge_en) begin
      ctrl_q[SUM_LO +: FLAG_W] <= flag_nxt;
    end
  end

  // R2: the upper byte moves only through an explicit write
  p_mask_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (ctrl_q[CTRL_W-1:CTRL_W-8] == $past(ctrl_q[CTRL_W-1:CTRL_W-8])));

  // R10: merged flags are sticky between writes
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ((ctrl_q & $past(ctrl_q)) == $past(ctrl_q)));

endmodule

// File: rtl/vfx_trap_encoder.sv
module vfx_trap_encoder
  import vfx_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CTRL_W    = 32,
  parameter int MASK_POS  = 24,
  parameter int SUM_POS   = 16,
  localparam int LANE_W   = $clog2(NUM_LANES),
  localparam int EN_LO    = MASK_POS + 8 - FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              op_start,
  input  logic              single_elem,
  input  logic              inexact_suppress,
  input  logic              lane_valid,
  input  logic [LANE_W-1:0] lane_idx,
  input  logic [FLAG_W-1:0] lane_flags,
  output logic              trap_valid,
  output logic [7:0]        trap_code,
  output logic              op_done,
  output logic              commit,
  output logic [FLAG_W-1:0] sum_flags,
  output logic [CTRL_W-1:0] ctrl_q
);

  cause_e            cause;
  logic              hit;
  logic              supp_q;
  logic              merge_en;
  logic [FLAG_W-1:0] merge_flags;

  vfx_lane_eval u_eval (
    .flags        (lane_flags),
    .enables      (ctrl_q[EN_LO +: FLAG_W]),
    .suppress_inx (supp_q),
    .cause        (cause),
    .hit          (hit)
  );

  vfx_op_seq #(.NUM_LANES(NUM_LANES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .op_start    (op_start),
    .single_in   (single_elem),
    .supp_in     (inexact_suppress),
    .lane_valid  (lane_valid),
    .lane_idx    (lane_idx),
    .lane_flags  (lane_flags),
    .cause       (cause),
    .hit         (hit),
    .supp_q      (supp_q),
    .merge_en    (merge_en),
    .merge_flags (merge_flags),
    .trap_valid  (trap_valid),
    .trap_code   (trap_code),
    .op_done     (op_done),
    .commit      (commit),
    .sum_flags   (sum_flags)
  );

  vfx_ctrl_reg #(.CTRL_W(CTRL_W), .SUM_POS(SUM_POS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr          (ctrl_wr),
    .wdata       (ctrl_wdata),
    .merge_en    (merge_en),
    .merge_flags (merge_flags),
    .ctrl_q      (ctrl_q)
  );

  // R10: a trap leaves the control register as it was
  p_no_merge_on_trap_r10: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && !$past(ctrl_wr)) |-> $stable(ctrl_q));

  // R5: the lane index in a trap code is a real lane
  p_code_lane_r5: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (int'(trap_code[7:4]) < NUM_LANES));

endmodule

// File: tb/vfx_trap_encoder_test.sv
`timescale 1ns/1ps
module vfx_trap_encoder_test;

  localparam int NL = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        ctrl_wr = 0;
  logic [31:0] ctrl_wdata = 0;
  logic        op_start = 0;
  logic        single_elem = 0;
  logic        inexact_suppress = 0;
  logic        lane_valid = 0;
  logic [1:0]  lane_idx = 0;
  logic [4:0]  lane_flags = 0;
  logic        trap_valid;
  logic [7:0]  trap_code;
  logic        op_done;
  logic        commit;
  logic [4:0]  sum_flags;
  logic [31:0] ctrl_q;

  vfx_trap_encoder uut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .op_start(op_start), .single_elem(single_elem),
    .inexact_suppress(inexact_suppress), .lane_valid(lane_valid),
    .lane_idx(lane_idx), .lane_flags(lane_flags), .trap_valid(trap_valid),
    .trap_code(trap_code), .op_done(op_done), .commit(commit),
    .sum_flags(sum_flags), .ctrl_q(ctrl_q)
  );

  always #2 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  string phase = "R1";
  bit    cmp_on = 0;
  bit    finished = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_active, m_single, m_supp;
  logic [4:0]  m_sum;
  logic [31:0] m_ctrl;
  bit          m_trap, m_done, m_commit;
  logic [7:0]  m_code;

  always @(posedge clk) begin
    logic [4:0] en;
    int         cz;
    bit         fin;
    logic [4:0] ns;
    if (rst) begin
      m_active = 0; m_single = 0; m_supp = 0; m_sum = 0; m_ctrl = 0;
      m_trap = 0; m_done = 0; m_commit = 0; m_code = 0;
    end else begin
      m_trap = 0; m_done = 0; m_commit = 0; m_code = 0;
      en = lane_flags & m_ctrl[31:27];
      cz = 0;
      for (int k = 1; k <= 4; k++)
        if (cz == 0 && en[5-k]) cz = k;
      if (cz == 0 && en[0] && !m_supp) cz = 5;
      if (op_start) begin
        m_active = 1; m_single = single_elem; m_supp = inexact_suppress;
        m_sum = 0;
        if (ctrl_wr) m_ctrl = ctrl_wdata;
      end else if (m_active && lane_valid) begin
        ns  = m_sum | lane_flags;
        fin = (cz != 0) || m_single || (int'(lane_idx) == NL - 1);
        m_sum = ns;
        m_trap = (cz != 0);
        m_code = (cz != 0) ? ((8'(lane_idx) << 4) | 8'(cz)) : 8'h00;
        m_done = fin;
        m_commit = fin && (cz == 0);
        if (fin) m_active = 0;
        if (ctrl_wr) m_ctrl = ctrl_wdata;
        else if (fin && cz == 0) m_ctrl[23:19] = m_ctrl[23:19] | ns;
      end else if (ctrl_wr) begin
        m_ctrl = ctrl_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check(phase, "trap_valid", 32'(trap_valid), 32'(m_trap));
      check(phase, "trap_code",  32'(trap_code),  32'(m_code));
      check(phase, "op_done",    32'(op_done),    32'(m_done));
      check(phase, "commit",     32'(commit),     32'(m_commit));
      check(phase, "sum_flags",  32'(sum_flags),  32'(m_sum));
      check(phase, "ctrl_q",     ctrl_q,          m_ctrl);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic start_op(input bit single, input bit supp);
    @(negedge clk); op_start = 1; single_elem = single; inexact_suppress = supp;
    @(negedge clk); op_start = 0; single_elem = 0; inexact_suppress = 0;
  endtask

  task automatic lane(input int i, input logic [4:0] f);
    @(negedge clk); lane_valid = 1; lane_idx = 2'(i); lane_flags = f;
    @(negedge clk); lane_valid = 0; lane_flags = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "trap_valid", 32'(trap_valid), 0);
    check("R1", "ctrl_q", ctrl_q, 0);
    check("R1", "sum_flags", 32'(sum_flags), 0);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    check("R1", "op_done", 32'(op_done), 0);

    // No enables: every lane runs, summary merged, commit given
    phase = "R10";
    start_op(0, 0);
    check("R9", "sum after start", 32'(sum_flags), 0);
    lane(0, 5'b00001);
    lane(1, 5'b00100);
    lane(2, 5'b00000);
    lane(3, 5'b10000);
    check("R11", "op_done", 32'(op_done), 1);
    check("R10", "commit", 32'(commit), 1);
    check("R10", "ctrl merged", ctrl_q, 32'h00A8_0000);

    // Invalid + overflow enabled; trap on lane 2, lane 3 ignored
    phase = "R7";
    wr_ctrl(32'hA000_0000);
    check("R2", "ctrl write", ctrl_q, 32'hA000_0000);
    start_op(0, 0);
    lane(0, 5'b00001);
    lane(1, 5'b00010);
    lane(2, 5'b10100);
    check("R5", "trap_valid", 32'(trap_valid), 1);
    check("R4", "trap_code", 32'(trap_code), 32'h21);
    check("R7", "op_done", 32'(op_done), 1);
    check("R10", "no commit", 32'(commit), 0);
    check("R10", "ctrl kept", ctrl_q, 32'hA000_0000);
    check("R9", "sum incl trap lane", 32'(sum_flags), 32'h17);
    lane(3, 5'b01000);
    check("R7", "ignored lane sum", 32'(sum_flags), 32'h17);
    check("R7", "ignored lane done", 32'(op_done), 0);

    // Priority: divide-by-zero over underflow
    phase = "R4";
    wr_ctrl(32'h5000_0000);
    start_op(0, 0);
    lane(0, 5'b00000);
    check("R3", "no flags no trap", 32'(trap_valid), 0);
    lane(1, 5'b01011);
    check("R4", "trap_code", 32'(trap_code), 32'h12);

    // Inexact suppression
    phase = "R6";
    wr_ctrl(32'h0800_0000);
    start_op(0, 1);
    for (int i = 0; i < NL; i++) lane(i, 5'b00001);
    check("R6", "suppressed trap", 32'(trap_valid), 0);
    check("R10", "ctrl merged inx", ctrl_q, 32'h0808_0000);
    start_op(0, 0);
    lane(0, 5'b00001);
    check("R6", "inexact trap code", 32'(trap_code), 32'h05);
    check("R10", "ctrl kept inx", ctrl_q, 32'h0808_0000);
    wr_ctrl(32'h2800_0000);
    start_op(0, 1);
    lane(0, 5'b00101);
    check("R6", "ovf through suppress", 32'(trap_code), 32'h03);

    // Single-element mode
    phase = "R8";
    wr_ctrl(32'h0000_0000);
    start_op(1, 0);
    lane(0, 5'b00010);
    check("R8", "op_done", 32'(op_done), 1);
    check("R8", "ctrl merged", ctrl_q, 32'h0010_0000);
    lane(1, 5'b10000);
    check("R8", "ignored sum", 32'(sum_flags), 32'h02);

    // All enabled, no flags anywhere
    phase = "R3";
    wr_ctrl(32'hF800_0000);
    start_op(0, 0);
    for (int i = 0; i < NL; i++) lane(i, 5'b00000);
    check("R3", "commit", 32'(commit), 1);
    check("R3", "ctrl", ctrl_q, 32'hF800_0000);

    // Register write collides with merge
    phase = "R2";
    wr_ctrl(32'h0000_0000);
    start_op(0, 0);
    for (int i = 0; i < NL - 1; i++) lane(i, 5'b00100);
    @(negedge clk); lane_valid = 1; lane_idx = 2'd3; lane_flags = 5'b00001;
    ctrl_wr = 1; ctrl_wdata = 32'h1234_5678;
    @(negedge clk); lane_valid = 0; ctrl_wr = 0;
    check("R2", "write wins", ctrl_q, 32'h1234_5678);
    check("R2", "commit", 32'(commit), 1);

    // Underflow on top lane
    phase = "R5";
    wr_ctrl(32'h1000_0000);
    start_op(0, 0);
    for (int i = 0; i < NL - 1; i++) lane(i, 5'b00000);
    lane(3, 5'b00010);
    check("R5", "top lane code", 32'(trap_code), 32'h34);
    @(negedge clk);
    check("R5", "code cleared", 32'(trap_code), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule